// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block turns one memory-mapped read request into a complete read transaction on a serial flash bus of up to four bidirectional lanes. A transaction runs through up to four phases: an 8-bit command, an address of 1 to 4 bytes, an optional run of idle (dummy) clock cycles, and a data phase that gathers `DATA_W` bits. The command, address and data phases each have their own lane width of 1, 2 or 4. The command byte comes from a built-in table indexed by the read mode, or from a programmable value in the two custom modes. The table switches to its 4-byte-address variant when that option is enabled and the address is 4 bytes wide.

Serial-clock timing comes from outside the block. An external divider raises `sck_tick` for one system clock per serial-clock period, at the rising edge of the serial clock. A chip-select controller holds `cs_grant` high while the transaction owns the bus. On each counted tick the flash takes the bits currently on the lanes. In the same system clock the sequencer captures the input lanes, when it is in the data phase, and then moves to the next bit group. When the last group has been captured, the assembled word appears on `rd_data` with a one-cycle `rd_valid` strobe.

Top module: `flash_read_seq`

## Requirements
- R1: When `busy` is low, `req_valid` is accepted at a clock edge. `req_addr` and all `cfg_*` inputs except `cfg_wp_level` are latched, and `busy` is high from the next cycle. A `req_valid` seen while `busy` is high has no effect on the transaction in progress.
- R2: The sequencer advances only on cycles where `busy`, `cs_grant` and `sck_tick` are all high. Ticks that arrive while `cs_grant` is low are ignored.
- R3: The command byte depends on `cfg_mode`. Modes 0 to 5 (standard, fast, dual-output, dual-I/O, quad-output, quad-I/O) use 0x03, 0x0B, 0x3B, 0xBB, 0x6B and 0xEB respectively, unless R4 applies.
- R4: When `cfg_op4b` is 1 and `cfg_addr_bytes` is 3 (4-byte address), modes 0 to 5 use 0x13, 0x0C, 0x3C, 0xBC, 0x6C and 0xEC instead.
- R5: Modes 6 (custom standard) and 7 (custom fast) send `cfg_custom_op` as the command byte.
- R6: The lane code is 0 for 1 lane, 1 for 2 lanes and 2 for 4 lanes. A phase of width w drives lanes 0..w-1. Each group is sent most significant bit first, and the earliest bit of a group goes on the highest lane. The command phase lasts 8/w ticks.
- R7: `cfg_addr_bytes` = n-1 selects an n-byte address made of the low 8n bits of `req_addr`. It is sent MSB first over 8n/w ticks.
- R8: A dummy phase of `cfg_dummy`+3 ticks (3 to 18) follows the address in every mode except 0 and 6. In modes 0 and 6 the data phase follows the address directly.
- R9: The data phase lasts `DATA_W`/w ticks. On each tick it captures `io_in[1]` (1 lane), `io_in[1:0]` (2 lanes) or `io_in[3:0]` (4 lanes). The first captured bit ends up at the MSB of `rd_data`.
- R10: Lane enables follow the phase. In the command and address phases, exactly lanes 0..w-1 are driven. In the dummy phase, modes 3 and 5 release every lane, and all other modes drive lane 0 low. In the data phase, only a 1-lane data width drives lane 0, and it drives it low.
- R11: While `busy` is high and the data lane code is not 4-lane, lane 2 drives `cfg_wp_level` in every phase except a 4-lane command or address phase.
- R12: When the last data group is captured, `busy` falls and `rd_valid` goes high for exactly one cycle, both in the same cycle.
- R13: While `busy` is low, `io_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 32 | Byte address of the read |
| busy | output | 1 | A transaction is in progress |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` is complete |
| rd_data | output | DATA_W | Assembled read data |
| sck_tick | input | 1 | One pulse per serial clock, at its rising edge |
| cs_grant | input | 1 | Bus granted by the chip-select controller |
| cfg_mode | input | 3 | Read mode 0 to 7 |
| cfg_lane_instr | input | 2 | Command phase lane code (3 acts as 1 lane) |
| cfg_lane_addr | input | 2 | Address phase lane code |
| cfg_lane_data | input | 2 | Data phase lane code |
| cfg_addr_bytes | input | 2 | Address length minus one, in bytes |
| cfg_dummy | input | 4 | Dummy ticks minus three |
| cfg_op4b | input | 1 | Use the 4-byte-address command table |
| cfg_custom_op | input | 8 | Command byte for modes 6 and 7 |
| cfg_wp_level | input | 1 | Static level for lane 2 |
| io_in | input | 4 | Lane input values |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |

## Verification
The bench sweeps all eight read modes against all four address lengths, with three lane and option variants for each pair. The fixed modes use their natural lane widths. The custom modes rotate through every width in every phase. Each run rebuilds the command and address from the recorded lane values. This separates the 3-byte table, the 4-byte table and the custom byte, and it exposes wrong group ordering at each width. The total tick count is compared with the sum of the phase lengths, which catches a dummy phase inserted or dropped in the wrong mode or with the wrong length. Some runs withdraw the grant in the middle and raise a second request while busy. Their results must match runs without those disturbances.

// File: rtl/flash_read_seq.sv
module flash_read_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sck_tick,
  input  logic              cs_grant,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_lane_instr,
  input  logic [1:0]        cfg_lane_addr,
  input  logic [1:0]        cfg_lane_data,
  input  logic [1:0]        cfg_addr_bytes,
  input  logic [3:0]        cfg_dummy,
  input  logic              cfg_op4b,
  input  logic [7:0]        cfg_custom_op,
  input  logic              cfg_wp_level,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);
  localparam int SPAN_MAX = (DATA_W > 32) ? DATA_W : 32;
  localparam int CW = $clog2(SPAN_MAX) + 1;

  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_ADDR, S_DUMMY, S_DATA} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic [31:0]       sh;
  logic [31:0]       addr_q;
  logic [DATA_W-1:0] rx;
  logic [2:0]        mode_q;
  logic [1:0]        li_q, la_q, ld_q, nb_q;
  logic [3:0]        dum_q;
  logic [7:0]        opc;
  logic [3:0]        grp;

  function automatic logic [1:0] lsh(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [CW-1:0] span(input int bits, input logic [1:0] s);
    return CW'((bits >> s) - 1);
  endfunction

  wire [1:0] s_i = lsh(li_q);
  wire [1:0] s_a = lsh(la_q);
  wire [1:0] s_d = lsh(ld_q);
  wire       wide = (st == S_INSTR) || (st == S_ADDR);
  wire [1:0] s_cur = (st == S_INSTR) ? s_i : (st == S_ADDR) ? s_a : s_d;
  wire       adv = busy && cs_grant && sck_tick;
  wire       last = (cnt == '0);
  wire       io_mode = (mode_q == 3'd3) || (mode_q == 3'd5);
  wire       has_dummy = !((mode_q == 3'd0) || (mode_q == 3'd6));
  wire       four = cfg_op4b && (cfg_addr_bytes == 2'd3);

  always_comb begin
    case (cfg_mode)
      3'd0:    opc = four ? 8'h13 : 8'h03;
      3'd1:    opc = four ? 8'h0C : 8'h0B;
      3'd2:    opc = four ? 8'h3C : 8'h3B;
      3'd3:    opc = four ? 8'hBC : 8'hBB;
      3'd4:    opc = four ? 8'h6C : 8'h6B;
      3'd5:    opc = four ? 8'hEC : 8'hEB;
      default: opc = cfg_custom_op;
    endcase
  end

  always_comb begin
    case (s_d)
      2'd1:    grp = {2'b00, io_in[1:0]};
      2'd2:    grp = io_in;
      default: grp = {3'b000, io_in[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      addr_q   <= '0;
      rx       <= '0;
      mode_q   <= '0;
      li_q     <= '0;
      la_q     <= '0;
      ld_q     <= '0;
      nb_q     <= '0;
      dum_q    <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          st     <= S_INSTR;
          mode_q <= cfg_mode;
          li_q   <= cfg_lane_instr;
          la_q   <= cfg_lane_addr;
          ld_q   <= cfg_lane_data;
          nb_q   <= cfg_addr_bytes;
          dum_q  <= cfg_dummy;
          addr_q <= req_addr;
          sh     <= {opc, 24'h0};
          cnt    <= span(8, lsh(cfg_lane_instr));
        end
      end else if (adv) begin
        case (st)
          S_INSTR: begin
            if (last) begin
              st  <= S_ADDR;
              sh  <= addr_q << {2'(2'd3 - nb_q), 3'b000};
              cnt <= span(8 * (int'(nb_q) + 1), s_a);
            end else begin
              sh  <= sh << (1 << s_i);
              cnt <= cnt - 1'b1;
            end
          end
          S_ADDR: begin
            if (last) begin
              if (has_dummy) begin
                st  <= S_DUMMY;
                cnt <= CW'(dum_q) + CW'(2);
              end else begin
                st  <= S_DATA;
                cnt <= span(DATA_W, s_d);
              end
            end else begin
              sh  <= sh << (1 << s_a);
              cnt <= cnt - 1'b1;
            end
          end
          S_DUMMY: begin
            if (last) begin
              st  <= S_DATA;
              cnt <= span(DATA_W, s_d);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_DATA: begin
            rx <= (rx << (1 << s_d)) | DATA_W'(grp);
            if (last) begin
              st       <= S_IDLE;
              busy     <= 1'b0;
              rd_valid <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: begin
            st   <= S_IDLE;
            busy <= 1'b0;
          end
        endcase
      end
    end
  end

  assign rd_data = rx;

  always_comb begin
    io_out = '0;
    io_oe  = '0;
    if (wide) begin
      case (s_cur)
        2'd1: begin
          io_oe[1:0]  = 2'b11;
          io_out[1:0] = sh[31:30];
        end
        2'd2: begin
          io_oe  = 4'hF;
          io_out = sh[31:28];
        end
        default: begin
          io_oe[0]  = 1'b1;
          io_out[0] = sh[31];
        end
      endcase
    end else if (st == S_DUMMY) begin
      io_oe[0] = !io_mode;
    end else if (st == S_DATA) begin
      io_oe[0] = (s_d == 2'd0);
    end
    if (busy && (s_d != 2'd2) && !(wide && (s_cur == 2'd2))) begin
      io_oe[2]  = 1'b1;
      io_out[2] = cfg_wp_level;
    end
  end

  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);

  assert_busy_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rd_valid);

  assert_hold_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_grant) |=> ($stable(cnt) && $stable(st) && $stable(sh)));

  assert_dummy_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUMMY) |-> (cnt <= CW'(17)));

  assert_idle_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (io_oe == 4'b0000));

endmodule

// File: tb/flash_read_seq_test.sv
module flash_read_seq_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          busy, rd_valid;
  logic [DW-1:0] rd_data;
  logic          sck_tick = 1'b0;
  logic          cs_grant = 1'b1;
  logic [2:0]    cfg_mode = '0;
  logic [1:0]    cfg_lane_instr = '0, cfg_lane_addr = '0, cfg_lane_data = '0;
  logic [1:0]    cfg_addr_bytes = '0;
  logic [3:0]    cfg_dummy = '0;
  logic          cfg_op4b = 1'b0;
  logic [7:0]    cfg_custom_op = '0;
  logic          cfg_wp_level = 1'b0;
  logic [3:0]    io_in = '0;
  logic [3:0]    io_out, io_oe;

  flash_read_seq #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .sck_tick(sck_tick), .cs_grant(cs_grant),
    .cfg_mode(cfg_mode), .cfg_lane_instr(cfg_lane_instr),
    .cfg_lane_addr(cfg_lane_addr), .cfg_lane_data(cfg_lane_data),
    .cfg_addr_bytes(cfg_addr_bytes), .cfg_dummy(cfg_dummy),
    .cfg_op4b(cfg_op4b), .cfg_custom_op(cfg_custom_op),
    .cfg_wp_level(cfg_wp_level), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int tix = 0;
  int val_cnt = 0;
  bit busy_bad = 1'b0;
  bit finished = 1'b0;
  logic [DW-1:0] got_data = '0;
  logic [3:0] rec_out [256];
  logic [3:0] rec_oe [256];

  function automatic logic [3:0] pat(input int i);
    return 4'(i * 5 + (i >> 3) + 3);
  endfunction

  function automatic int width_of(input int code);
    return (code == 1) ? 2 : (code == 2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] take(input logic [3:0] v, input int w);
    if (w == 1) return {3'b000, v[0]};
    if (w == 2) return {2'b00, v[1:0]};
    return v;
  endfunction

  function automatic logic [7:0] exp_op(input int m, input bit four, input logic [7:0] c);
    case (m)
      0: return four ? 8'h13 : 8'h03;
      1: return four ? 8'h0C : 8'h0B;
      2: return four ? 8'h3C : 8'h3B;
      3: return four ? 8'hBC : 8'hBB;
      4: return four ? 8'h6C : 8'h6B;
      5: return four ? 8'hEC : 8'hEB;
      default: return c;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        val_cnt++;
        got_data = rd_data;
        if (busy) busy_bad = 1'b1;
      end
      sck_tick = (div == 3);
      div = (div + 1) % 4;
      io_in = pat(tix);
      if (sck_tick && busy && cs_grant) begin
        rec_out[tix % 256] = io_out;
        rec_oe[tix % 256] = io_oe;
        tix++;
      end
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete");
      summary();
      $finish;
    end
  end

  task automatic run(input int mode, input int li, input int la, input int ld,
                     input int nb, input int dm, input bit op4, input bit wp,
                     input logic [7:0] cop, input logic [31:0] addr, input bit gap);
    int base, v0, wi, wa, wd, ni, na, nd, ndt, tot, oe_bad, wp_bad;
    bit four, io;
    logic [63:0] acc_op, acc_ad, acc_dt, exp_ad;
    logic [3:0] e;
    string tag;
    wi = width_of(li); wa = width_of(la); wd = width_of(ld);
    @(posedge clk); #2;
    cfg_mode = 3'(mode); cfg_lane_instr = 2'(li); cfg_lane_addr = 2'(la);
    cfg_lane_data = 2'(ld); cfg_addr_bytes = 2'(nb - 1); cfg_dummy = 4'(dm);
    cfg_op4b = op4; cfg_wp_level = wp; cfg_custom_op = cop;
    req_valid = 1'b1; req_addr = addr;
    base = tix; v0 = val_cnt; busy_bad = 1'b0;
    @(posedge clk); #2;
    req_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", longint'(busy), 1);
    cfg_mode = 3'(7 - mode); cfg_addr_bytes = 2'(4 - nb); cfg_custom_op = ~cop;
    if (gap) begin
      req_valid = 1'b1; req_addr = ~addr;
      @(posedge clk); #2;
      req_valid = 1'b0;
      repeat (6) @(posedge clk);
      #2 cs_grant = 1'b0;
      repeat (30) @(posedge clk);
      #2 cs_grant = 1'b1;
    end
    while (val_cnt == v0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
    four = op4 && (nb == 4);
    io = (mode == 3) || (mode == 5);
    ni = 8 / wi; na = nb * 8 / wa;
    nd = (mode == 0 || mode == 6) ? 0 : dm + 3;
    ndt = DW / wd;
    tot = ni + na + nd + ndt;
    chk((tix - base) == tot, "R8", "tick count", longint'(tix - base), longint'(tot));
    if (gap) chk((tix - base) == tot, "R2", "ticks with grant pause", longint'(tix - base), longint'(tot));
    acc_op = '0; acc_ad = '0; acc_dt = '0; oe_bad = 0; wp_bad = 0;
    for (int k = 0; k < tot; k++) begin
      int ph, w, idx;
      logic [3:0] p;
      idx = (base + k) % 256;
      ph = (k < ni) ? 0 : (k < ni + na) ? 1 : (k < ni + na + nd) ? 2 : 3;
      w = (ph == 0) ? wi : (ph == 1) ? wa : wd;
      if (ph == 0) acc_op = (acc_op << wi) | 64'(take(rec_out[idx], wi));
      if (ph == 1) acc_ad = (acc_ad << wa) | 64'(take(rec_out[idx], wa));
      if (ph == 3) begin
        p = pat(base + k);
        acc_dt = (acc_dt << wd) | ((wd == 1) ? 64'(p[1]) : (wd == 2) ? 64'(p[1:0]) : 64'(p));
      end
      if (ph < 2) e = (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
      else if (ph == 2) e = io ? 4'b0000 : 4'b0001;
      else e = (wd == 1) ? 4'b0001 : 4'b0000;
      if (!(ph < 2 && w == 4) && wd != 4) begin
        e[2] = 1'b1;
        if (rec_out[idx][2] !== wp) wp_bad++;
      end
      if (rec_oe[idx] !== e) oe_bad++;
    end
    tag = (mode >= 6) ? "R5" : four ? "R4" : "R3";
    chk(acc_op[7:0] == exp_op(mode, four, cop), tag, "command byte",
        longint'(acc_op[7:0]), longint'(exp_op(mode, four, cop)));
    chk(acc_op[7:0] == exp_op(mode, four, cop), "R6", "command lane order",
        longint'(acc_op[7:0]), longint'(exp_op(mode, four, cop)));
    exp_ad = (nb == 4) ? 64'(addr) : (64'(addr) & ((64'd1 << (8 * nb)) - 1));
    chk(acc_ad == exp_ad, "R7", "address", longint'(acc_ad), longint'(exp_ad));
    if (gap) chk(acc_ad == exp_ad, "R1", "address ignores second request",
                 longint'(acc_ad), longint'(exp_ad));
    chk(got_data == DW'(acc_dt), "R9", "read data", longint'(got_data), longint'(acc_dt));
    chk(oe_bad == 0, "R10", "lane enables mismatching ticks", longint'(oe_bad), 0);
    chk(wp_bad == 0, "R11", "lane 2 level mismatching ticks", longint'(wp_bad), 0);
    chk((val_cnt - v0) == 1 && !busy_bad, "R12", "valid cycles",
        longint'(val_cnt - v0), 1);
    chk(io_oe == 4'b0000 && !busy, "R13", "idle lane enables", longint'(io_oe), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12", "reset busy", longint'(busy), 0);
    chk(rd_valid == 1'b0, "R12", "reset valid", longint'(rd_valid), 0);
    chk(io_oe == 4'b0000, "R13", "reset lane enables", longint'(io_oe), 0);
    for (int mode = 0; mode < 8; mode++) begin
      for (int nb = 1; nb <= 4; nb++) begin
        for (int v = 0; v < 3; v++) begin
          int li, la, ld;
          case (mode)
            2: begin li = 0; la = 0; ld = 1; end
            3: begin li = 0; la = 1; ld = 1; end
            4: begin li = 0; la = 0; ld = 2; end
            5: begin li = 0; la = 2; ld = 2; end
            6, 7: begin li = v; la = (v + 1) % 3; ld = (v + 2) % 3; end
            default: begin li = 0; la = 0; ld = 0; end
          endcase
          run(mode, li, la, ld, nb, (mode * 4 + nb * 3 + v * 5) % 16,
              v != 0, v[0], 8'(8'h5A ^ (mode * 16 + nb)),
              32'hA5C3_0F00 + 32'(mode * 32'h1111) + 32'(nb * 32'h77) + 32'(v * 32'h3141_0000),
              (v == 2) && (nb == 2));
        end
      end
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule